// File: doc/BRIEF.md
# Fractional Half-Second Tick Generator

The block turns a fast core clock into an exact half-second event, a one-second square wave and a running seconds count. A plain modulo-N divider would need a wide comparator and could not represent a period that is not a whole number of prescaled ticks. This block avoids both. A fixed prescaler steps an 8-bit wrap-around counter. Control logic counts the counter's wraps. After the last full wrap it preloads the counter, so that the final partial span is only the leftover tick count. A small power-of-two accumulator stretches that partial span by one tick often enough to absorb the fractional part of the period.

With the default 8 MHz settings, one half second is 3906.25 prescaled ticks. That is 15 full wraps, then 66 ticks, with one extra tick in every fourth half second. The parameters also cover slower cores, for example a 400 kHz core with a divide-by-256 prescaler, 3 wraps and a 13-tick remainder. A prescaler enable input freezes all timing state while it is low.

Top module: `halftick_gen`

## Requirements
- R1: While `rst` is high at a rising edge, every state element clears, so `halfPulse`, `secondWave` and `secondsCount` read 0 after that edge. After release, timing restarts from the beginning of a half-second cycle with the fraction accumulator at zero.
- R2: The counter advances one step per `PRE_DIV` clock edges at which `tickEn` is high. Edges with `tickEn` low change no timing state, and a `halfPulse` only follows an edge with `tickEn` high.
- R3: A half-second cycle without the fractional extension spans exactly `PRE_DIV * (FULL_WRAPS * 2^CNT_W + TAIL_TICKS)` enabled edges.
- R4: The fraction accumulator gains `FRAC_NUM` once per half-second cycle, modulo `FRAC_DEN`. The cycle in which the sum reaches `FRAC_DEN` is one prescaled tick longer. With 1/4 this is every fourth cycle, counting from reset. Four consecutive cycles therefore total `PRE_DIV * (4*FULL_WRAPS*2^CNT_W + 4*TAIL_TICKS + 1)` enabled edges, which is 15625 prescaled ticks at the defaults.
- R5: `halfPulse` is high for exactly one clock after each completed half-second cycle.
- R6: `secondWave` changes only in the cycle in which `halfPulse` is high, and it inverts there. It starts low, so the first pulse after reset drives it high.
- R7: `secondsCount` increases by exactly one in the cycle in which a pulse drives `secondWave` low, that is, on every second pulse. It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | Prescaler enable; low freezes all timing state |
| halfPulse | output | 1 | One-cycle strobe at the end of each half second |
| secondWave | output | 1 | Square wave that toggles on every half-second strobe |
| secondsCount | output | SEC_W | Seconds counter, steps on every falling edge of `secondWave` |

## Verification
The hardest case to reach from the ports is the lengthened cycle. It comes up only once in four half seconds, and it only shows as a single extra prescaled tick. Small prescaler and wrap counts in the bench keep a half second to a few thousand clocks. This lets many cycles, including several lengthened ones, fit in one run. The gap between pulses is then measured exactly, one cycle at a time and summed over four cycles. A long stretch with a periodically dropped enable moves the lengthened cycle's preload onto arbitrary prescaler phases. A reset in the middle of a cycle checks that both the accumulator phase and the wrap count restart.

// File: rtl/halftick_pkg.sv
package halftick_pkg;

  // Control -> datapath strobes
  typedef struct packed {
    logic loadTail;   // at this wrap, load the partial-span start value
    logic extraTick;  // lengthen the partial span by one tick
  } ctlStrobes_t;

  // Datapath -> control status
  typedef struct packed {
    logic tick;       // prescaled tick this cycle
    logic wrap;       // counter wraps on this tick
  } dpStatus_t;

endpackage

// File: rtl/halftick_datapath.sv
module halftick_datapath
  import halftick_pkg::*;
#(
  parameter int PRE_DIV    = 1024,
  parameter int CNT_W      = 8,
  parameter int TAIL_TICKS = 66
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tickEn,
  input  ctlStrobes_t ctl,
  output dpStatus_t   stat
);

  localparam int PS_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRE_DIV - 1);
  localparam logic [CNT_W:0] SPAN = (CNT_W+1)'(1) << CNT_W;
  localparam logic [CNT_W:0] TAIL = (CNT_W+1)'(TAIL_TICKS);

  logic [PS_W-1:0]  preCnt;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W:0]   tailStart;

  // Start value of the partial span: full span minus the tick count still to go
  assign tailStart = SPAN - TAIL - {{CNT_W{1'b0}}, ctl.extraTick};

  assign stat.tick = tickEn && (preCnt == PS_LAST);
  assign stat.wrap = stat.tick && (tickCnt == {CNT_W{1'b1}});

  generate
    if (PRE_DIV > 1) begin : g_prescale
      always_ff @(posedge clk) begin
        if (rst)               preCnt <= '0;
        else if (tickEn) begin
          if (preCnt == PS_LAST) preCnt <= '0;
          else                   preCnt <= preCnt + 1'b1;
        end
      end
    end else begin : g_noPrescale
      always_ff @(posedge clk) preCnt <= '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) tickCnt <= '0;
    else if (stat.tick) begin
      if (stat.wrap) tickCnt <= ctl.loadTail ? tailStart[CNT_W-1:0] : '0;
      else           tickCnt <= tickCnt + 1'b1;
    end
  end

endmodule

// File: rtl/halftick_control.sv
module halftick_control
  import halftick_pkg::*;
#(
  parameter int FULL_WRAPS = 15,
  parameter int FRAC_NUM   = 1,
  parameter int FRAC_DEN   = 4,
  parameter int SEC_W      = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStatus_t        stat,
  output ctlStrobes_t      ctl,
  output logic             halfPulse,
  output logic             secondWave,
  output logic [SEC_W-1:0] secondsCount
);

  localparam int OVF_W  = $clog2(FULL_WRAPS + 1);
  localparam int FRAC_W = (FRAC_DEN > 1) ? $clog2(FRAC_DEN) : 1;
  localparam logic [OVF_W-1:0]  LOAD_AT = OVF_W'(FULL_WRAPS - 1);
  localparam logic [OVF_W-1:0]  LAST_AT = OVF_W'(FULL_WRAPS);
  localparam logic [FRAC_W:0]   F_NUM   = (FRAC_W+1)'(FRAC_NUM);
  localparam logic [FRAC_W:0]   F_DEN   = (FRAC_W+1)'(FRAC_DEN);

  logic [OVF_W-1:0]  wrapCount;
  logic [FRAC_W-1:0] fracAcc;
  logic [FRAC_W:0]   fracSum;
  logic              loadNow;
  logic              lastWrap;

  assign fracSum  = {1'b0, fracAcc} + F_NUM;
  assign loadNow  = stat.wrap && (wrapCount == LOAD_AT);
  assign lastWrap = stat.wrap && (wrapCount == LAST_AT);

  assign ctl.loadTail  = loadNow;
  assign ctl.extraTick = (fracSum >= F_DEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      wrapCount <= '0;
    end else if (lastWrap) begin
      wrapCount <= '0;
    end else if (stat.wrap) begin
      wrapCount <= wrapCount + 1'b1;
    end
  end

  // Fraction advances only at the preload, ahead of the partial span
  always_ff @(posedge clk) begin
    if (rst)          fracAcc <= '0;
    else if (loadNow) fracAcc <= fracSum[FRAC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halfPulse    <= 1'b0;
      secondWave   <= 1'b0;
      secondsCount <= '0;
    end else begin
      halfPulse <= lastWrap;
      if (lastWrap) begin
        secondWave <= ~secondWave;
        if (secondWave) secondsCount <= secondsCount + 1'b1;
      end
    end
  end

endmodule

// File: rtl/halftick_gen.sv
module halftick_gen
  import halftick_pkg::*;
#(
  parameter int PRE_DIV    = 1024,
  parameter int CNT_W      = 8,
  parameter int FULL_WRAPS = 15,
  parameter int TAIL_TICKS = 66,
  parameter int FRAC_NUM   = 1,
  parameter int FRAC_DEN   = 4,
  parameter int SEC_W      = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tickEn,
  output logic             halfPulse,
  output logic             secondWave,
  output logic [SEC_W-1:0] secondsCount
);

  ctlStrobes_t ctl;
  dpStatus_t   stat;

  halftick_datapath #(
    .PRE_DIV(PRE_DIV), .CNT_W(CNT_W), .TAIL_TICKS(TAIL_TICKS)
  ) u_dp (
    .clk(clk), .rst(rst), .tickEn(tickEn), .ctl(ctl), .stat(stat)
  );

  halftick_control #(
    .FULL_WRAPS(FULL_WRAPS), .FRAC_NUM(FRAC_NUM), .FRAC_DEN(FRAC_DEN), .SEC_W(SEC_W)
  ) u_ctl (
    .clk(clk), .rst(rst), .stat(stat), .ctl(ctl),
    .halfPulse(halfPulse), .secondWave(secondWave), .secondsCount(secondsCount)
  );

endmodule

// File: rtl/halftick_assert.sv
module halftick_assert #(
  parameter int SEC_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tickEn,
  input logic             halfPulse,
  input logic             secondWave,
  input logic [SEC_W-1:0] secondsCount
);

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    halfPulse |=> !halfPulse); // R5

  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    halfPulse |-> $past(tickEn)); // R2

  AST_WAVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !halfPulse |-> $stable(secondWave)); // R6

  AST_WAVE_FLIPS: assert property (@(posedge clk) disable iff (rst)
    halfPulse |-> (secondWave != $past(secondWave))); // R6

  AST_SECONDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!halfPulse || secondWave) |-> $stable(secondsCount)); // R7

  AST_SECONDS_STEP: assert property (@(posedge clk) disable iff (rst)
    (halfPulse && !secondWave) |-> (secondsCount == $past(secondsCount) + 1'b1)); // R7

endmodule

bind halftick_gen halftick_assert #(.SEC_W(SEC_W)) u_assert (
  .clk(clk), .rst(rst), .tickEn(tickEn), .halfPulse(halfPulse),
  .secondWave(secondWave), .secondsCount(secondsCount)
);

// File: tb/test_halftick_gen.sv
module test_halftick_gen;

  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int CW   = 8;
  localparam int FULL = 3;
  localparam int TAIL = 13;
  localparam int NUM  = 1;
  localparam int DEN  = 4;
  localparam int SW   = 32;
  localparam int HALF_TICKS = FULL * (1 << CW) + TAIL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickEn = 1'b0;
  logic halfPulse, secondWave;
  logic [SW-1:0] secondsCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  halftick_gen #(
    .PRE_DIV(DIV), .CNT_W(CW), .FULL_WRAPS(FULL), .TAIL_TICKS(TAIL),
    .FRAC_NUM(NUM), .FRAC_DEN(DEN), .SEC_W(SW)
  ) i_halftick_gen (
    .clk(clk), .rst(rst), .tickEn(tickEn), .halfPulse(halfPulse),
    .secondWave(secondWave), .secondsCount(secondsCount)
  );

  int nTests = 0;
  int nFail  = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model: counts enabled edges against the expected cycle length
  logic rstS = 1'b1, enS = 1'b0;
  always @(posedge clk) begin
    rstS <= rst;
    enS  <= tickEn;
  end

  int  enCount = 0;
  int  halfIdx = 0;
  bit  expPulse = 0;
  bit  expWave  = 0;
  logic [SW-1:0] expSec = '0;
  int  cyc = 0;
  int  pulseCount = 0;
  int  pulseCyc[$];

  function automatic int cycleLen(int idx);
    int extra;
    extra = (((idx + 1) * NUM) / DEN > (idx * NUM) / DEN) ? 1 : 0;
    return DIV * (HALF_TICKS + extra);
  endfunction

  always @(negedge clk) begin
    cyc++;
    expPulse = 0;
    if (rstS) begin
      enCount = 0; halfIdx = 0; expWave = 0; expSec = '0;
    end else if (enS) begin
      enCount++;
      if (enCount == cycleLen(halfIdx)) begin
        expPulse = 1;
        enCount = 0;
        halfIdx++;
        if (expWave) expSec = expSec + 1;
        expWave = ~expWave;
      end
    end
    check(halfPulse === expPulse, "R5", "halfPulse", halfPulse, expPulse);
    check(secondWave === expWave, "R6", "secondWave", secondWave, expWave);
    check(secondsCount === expSec, "R7", "secondsCount", secondsCount, expSec);
    if (halfPulse === 1'b1) begin
      pulseCount++;
      pulseCyc.push_back(cyc);
    end
  end

  task automatic drive(bit r, bit e);
    @(posedge clk);
    #(CLK_PERIOD/4);
    rst = r;
    tickEn = e;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p0, w0;
    logic [SW-1:0] s0;
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b1);
    #1;
    check(halfPulse == 0 && secondWave == 0 && secondsCount == 0, "R1",
          "outputs in reset", {secondWave, halfPulse}, 0);

    // Phase 1: enable held, measure exact spacing
    drive(1'b0, 1'b1);
    while (pulseCyc.size() < 5) @(posedge clk);
    check(pulseCyc[1] - pulseCyc[0] == DIV * HALF_TICKS, "R3", "plain cycle",
          pulseCyc[1] - pulseCyc[0], DIV * HALF_TICKS);
    check(pulseCyc[2] - pulseCyc[1] == DIV * HALF_TICKS, "R3", "plain cycle 2",
          pulseCyc[2] - pulseCyc[1], DIV * HALF_TICKS);
    check(pulseCyc[3] - pulseCyc[2] == DIV * (HALF_TICKS + 1), "R4", "lengthened cycle",
          pulseCyc[3] - pulseCyc[2], DIV * (HALF_TICKS + 1));
    check(pulseCyc[4] - pulseCyc[0] == DIV * (4 * HALF_TICKS + 1), "R4", "four-cycle sum",
          pulseCyc[4] - pulseCyc[0], DIV * (4 * HALF_TICKS + 1));
    check(secondsCount == 2, "R7", "seconds after 5 halves", secondsCount, 2);

    // Phase 2: enable dropped every third cycle
    for (int i = 0; i < 25000; i++) drive(1'b0, (i % 3) != 2);

    // Frozen stretch
    drive(1'b0, 1'b0);
    #1;
    p0 = pulseCount; w0 = secondWave; s0 = secondsCount;
    for (int i = 0; i < 600; i++) drive(1'b0, 1'b0);
    #1;
    check(pulseCount == p0, "R2", "pulses while disabled", pulseCount, p0);
    check(secondWave == w0 && secondsCount == s0, "R2", "state while disabled",
          secondsCount, s0);

    // Phase 3: reset in the middle of a cycle
    for (int i = 0; i < 1000; i++) drive(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b1);
    drive(1'b0, 1'b1);
    #1;
    check(halfPulse == 0 && secondWave == 0 && secondsCount == 0, "R1",
          "outputs after mid reset", secondsCount, 0);
    p0 = pulseCount;
    while (pulseCount < p0 + 4) @(posedge clk);
    @(negedge clk);
    check(pulseCyc[pulseCyc.size()-1] - pulseCyc[pulseCyc.size()-2] == DIV * (HALF_TICKS + 1),
          "R4", "lengthened cycle after reset",
          pulseCyc[pulseCyc.size()-1] - pulseCyc[pulseCyc.size()-2], DIV * (HALF_TICKS + 1));
    check(secondsCount == 2, "R7", "seconds after reset", secondsCount, 2);
    check(secondWave == 0, "R6", "wave after even pulses", secondWave, 0);
    finish_run();
  end

endmodule